// File: doc/BRIEF.md
# Serial-bus register slave for LED bank control

This block is a two-wire serial-bus slave (I2C-compatible) that holds the control registers of a three-bank LED driver. A bus master addresses it, names a register in a second byte and writes its value in a third byte. A read transfer returns the register that was selected last. The register contents are decoded into bank enables, a voltage-sense enable and brightness levels. These fields feed the current-sink and charge-pump logic of the chip.

SCL and SDA enter as plain inputs. Each passes through a synchroniser and an edge detector clocked by the system clock, which must run at least 16 times the SCL rate. The slave answers through `sda_pull_o`, an open-drain request: 1 means pull SDA low. An active-low hardware reset pin clears the state asynchronously and drives the chip to its disabled state.

The link controller has ten states:
- ST_IDLE waits for START.
- ST_ADDR shifts the address byte. It goes to ST_ADDR_ACK on a match and to ST_IGNORE on a mismatch.
- From ST_ADDR_ACK the controller goes to ST_REG for a write or to ST_TX for a read.
- ST_REG shifts the register byte and goes to ST_REG_ACK, which then goes to ST_DATA.
- ST_DATA shifts a data byte and goes to ST_DATA_ACK, which returns to ST_DATA.
- ST_TX shifts a byte out and goes to ST_TX_ACK. On a master acknowledge it returns to ST_TX; on a not-acknowledge it goes to ST_IGNORE.
- From every state, START leads to ST_ADDR and STOP leads to ST_IDLE.

Top module: `ledctl_i2c_regs`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts the address phase in the same way as a first START. STOP returns the slave to idle. A byte clocked without a preceding START is not acknowledged.
- R2: The first byte carries the device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). The address is 36h by default and 38h when ALT_ADDR = 1. On a mismatch the slave gives no acknowledge. It then neither acknowledges nor writes anything until the next START or STOP.
- R3: While the slave is addressed, it holds `sda_pull_o` high during the 9th SCL clock of every byte it receives: the address byte, the register byte and each data byte.
- R4: In a write, the second byte selects the register and the third byte is stored into it. Further data bytes in the same transfer overwrite the same register.
- R5: The power-on and reset values are 10h = 20h, A0h = E0h, B0h = E0h and C0h = FCh.
- R6: A write to any register address other than 10h, A0h, B0h or C0h is acknowledged and discarded. A read of such an address returns 00h.
- R7: In a read, the slave shifts out the selected register MSB first, changing SDA only while SCL is low. If the master acknowledges, the same register is sent again. If the master does not acknowledge, the slave stays silent until START or STOP.
- R8: `hw_rst_n` low restores the R5 values at once, without waiting for a clock. It also aborts any transfer, releases SDA and forces `chip_off_o` high.
- R9: The fields of register 10h map to the outputs as follows:
  - bit 0 drives `en_main_o`
  - bit 1 drives `en_sub_o`
  - bit 2 drives `en_ind_o`
  - bit 3 drives `sense_a5_o`
  - bit 4 drives `en_b3_o`

  The level outputs are `lvl_a_o` = A0h[4:0], `lvl_b_o` = B0h[4:0] and `lvl_c_o` = C0h[1:0]. All other bits are stored and read back but reach no output. `chip_off_o` is 1 while bits 2:0 of 10h are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain) |
| en_main_o | output | 1 | Main bank enable |
| en_sub_o | output | 1 | Secondary bank enable |
| en_ind_o | output | 1 | Indicator sink enable |
| sense_a5_o | output | 1 | Fifth main sink voltage-sense enable |
| en_b3_o | output | 1 | Third secondary sink enable |
| lvl_a_o | output | 5 | Main bank brightness code |
| lvl_b_o | output | 5 | Secondary bank brightness code |
| lvl_c_o | output | 2 | Indicator brightness code |
| chip_off_o | output | 1 | Global disable flag |

## Verification
The bench tries every device address other than its own. If the compare were off by one bit or left out, a foreign address would be acknowledged, or the following bytes would write a register. It sweeps several data patterns through each mapped register, with varied unused bits. A decode error would then show up as a field on the wrong output or a wrong read-back, and a miscounted bit counter would store a shifted value. It also checks four edge cases:
- unmapped writes, which a sloppy decoder would alias onto a real register;
- a repeated START placed in the middle of a transfer;
- a read that continues after the master's not-acknowledge, where a wrong design keeps driving SDA;
- a hardware reset in the middle of a byte, which must release SDA and restore every value before any clock edge.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } link_state_t;

    localparam logic [6:0] DEV_ADDR_MAIN = 7'h36;
    localparam logic [6:0] DEV_ADDR_ALT  = 7'h38;

    // slot 0: enables, slot 1..3: brightness levels
    function automatic logic [BYTE_W-1:0] slot_addr(input int idx);
        case (idx)
            0:       return 8'h10;
            1:       return 8'hA0;
            2:       return 8'hB0;
            default: return 8'hC0;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] slot_por(input int idx);
        case (idx)
            0:       return 8'h20;
            1:       return 8'hE0;
            2:       return 8'hE0;
            default: return 8'hFC;
        endcase
    endfunction

endpackage

// File: rtl/ledctl_bus_sync.sv
module ledctl_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_q;
    logic sda_q;
    logic scl_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_lvl;
            sda_q    <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    // SDA edges count as framing only while SCL stays high
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/ledctl_i2c_link.sv
module ledctl_i2c_link
    import ledctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEV_ADDR_MAIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] reg_ptr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    link_state_t       state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              rw_q;
    logic              m_ack;
    logic              byte_done;

    assign byte_done = scl_fall && (cnt == CNT_FULL);

    always_comb begin
        nxt = state;
        if (start_det)     nxt = ST_ADDR;
        else if (stop_det) nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: nxt = state;
                ST_ADDR:     if (byte_done)
                                 nxt = (rx_sr[BYTE_W-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_TX : ST_REG;
                ST_REG:      if (byte_done) nxt = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                ST_TX:       if (scl_fall && cnt == CNT_LAST) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) nxt = m_ack ? ST_TX : ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            rw_q    <= 1'b0;
            m_ack   <= 1'b0;
            reg_ptr <= '0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else if (scl_rise) begin
            if (state == ST_ADDR || state == ST_REG || state == ST_DATA) begin
                rx_sr <= {rx_sr[BYTE_W-2:0], sda_lvl};
                cnt   <= cnt + 1'b1;
            end
            if (state == ST_TX_ACK) m_ack <= ~sda_lvl;
        end else if (scl_fall) begin
            unique case (state)
                ST_ADDR: if (cnt == CNT_FULL) begin
                    rw_q <= rx_sr[0];
                    cnt  <= '0;
                end
                ST_ADDR_ACK: if (rw_q) begin
                    tx_sr <= rd_data;
                    cnt   <= '0;
                end
                ST_REG: if (cnt == CNT_FULL) begin
                    reg_ptr <= rx_sr;
                    cnt     <= '0;
                end
                ST_DATA: if (cnt == CNT_FULL) cnt <= '0;
                ST_TX: begin
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                    cnt   <= cnt + 1'b1;
                end
                ST_TX_ACK: if (m_ack) begin
                    tx_sr <= rd_data;
                    cnt   <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr_data  = rx_sr;
        wr_en    = (state == ST_DATA) && byte_done;
        sda_pull = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_REG_ACK, ST_DATA_ACK: sda_pull = 1'b1;
            ST_TX:                                sda_pull = ~tx_sr[BYTE_W-1];
            default:                              sda_pull = 1'b0;
        endcase
    end

    assert_start_enters_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));
    assert_stop_goes_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));
    assert_ack_follows_reg_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REG && byte_done && !start_det && !stop_det) |=> sda_pull);
    assert_ignore_is_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_pull && !wr_en));

endmodule

// File: rtl/ledctl_regfile.sv
module ledctl_regfile
    import ledctl_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [BYTE_W-1:0]                  wr_addr,
    input  logic [BYTE_W-1:0]                  wr_data,
    input  logic [BYTE_W-1:0]                  rd_addr,
    output logic [BYTE_W-1:0]                  rd_data,
    output logic [NUM_SLOTS-1:0][BYTE_W-1:0]   regs
);
    logic wr_hit;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= slot_por(g);
            else if (wr_en && wr_addr == slot_addr(g)) q <= wr_data;
        end
        assign regs[g] = q;
    end

    always_comb begin
        rd_data = '0;
        wr_hit  = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_addr == slot_addr(i)) rd_data = regs[i];
            if (wr_addr == slot_addr(i)) wr_hit  = 1'b1;
        end
    end

    assert_mapped_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == slot_addr(1)) |=> (regs[1] == $past(wr_data)));
    assert_unmapped_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> $stable(regs));

endmodule

// File: rtl/ledctl_i2c_regs.sv
module ledctl_i2c_regs
    import ledctl_pkg::*;
#(
    parameter bit ALT_ADDR    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       hw_rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       en_main_o,
    output logic       en_sub_o,
    output logic       en_ind_o,
    output logic       sense_a5_o,
    output logic       en_b3_o,
    output logic [4:0] lvl_a_o,
    output logic [4:0] lvl_b_o,
    output logic [1:0] lvl_c_o,
    output logic       chip_off_o
);
    localparam logic [6:0] DEV_ADDR = ALT_ADDR ? DEV_ADDR_ALT : DEV_ADDR_MAIN;

    logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic wr_en;
    logic [BYTE_W-1:0] reg_ptr, wr_data, rd_data;
    logic [NUM_SLOTS-1:0][BYTE_W-1:0] regs;

    ledctl_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (hw_rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ledctl_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (hw_rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull_o),
        .wr_en     (wr_en),
        .reg_ptr   (reg_ptr),
        .wr_data   (wr_data)
    );

    ledctl_regfile u_regs (
        .clk     (clk),
        .rst_n   (hw_rst_n),
        .wr_en   (wr_en),
        .wr_addr (reg_ptr),
        .wr_data (wr_data),
        .rd_addr (reg_ptr),
        .rd_data (rd_data),
        .regs    (regs)
    );

    assign en_main_o  = regs[0][0];
    assign en_sub_o   = regs[0][1];
    assign en_ind_o   = regs[0][2];
    assign sense_a5_o = regs[0][3];
    assign en_b3_o    = regs[0][4];
    assign lvl_a_o    = regs[1][4:0];
    assign lvl_b_o    = regs[2][4:0];
    assign lvl_c_o    = regs[3][1:0];
    assign chip_off_o = ~hw_rst_n | ~|regs[0][2:0];

endmodule

// File: tb/ledctl_i2c_regs_tb.sv
module ledctl_i2c_regs_tb;
    localparam int H = 10;
    localparam logic [6:0] DEV = 7'h36;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic en_main, en_sub, en_ind, sense_a5, en_b3, chip_off;
    logic [4:0] lvl_a, lvl_b;
    logic [1:0] lvl_c;
    wire sda_bus = m_sda & ~sda_pull;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [4];
    bit done = 1'b0;

    always #2 clk = ~clk;

    ledctl_i2c_regs u_dut (
        .clk(clk), .hw_rst_n(hw_rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .en_main_o(en_main), .en_sub_o(en_sub),
        .en_ind_o(en_ind), .sense_a5_o(sense_a5), .en_b3_o(en_b3),
        .lvl_a_o(lvl_a), .lvl_b_o(lvl_b), .lvl_c_o(lvl_c), .chip_off_o(chip_off)
    );

    function automatic logic [7:0] addr_of(input int i);
        case (i) 0: return 8'h10; 1: return 8'hA0; 2: return 8'hB0; default: return 8'hC0; endcase
    endfunction

    task automatic model_por();
        model[0] = 8'h20; model[1] = 8'hE0; model[2] = 8'hE0; model[3] = 8'hFC;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_fields(input string req);
        chk({req, " en_main"},  en_main,  model[0][0]);
        chk({req, " en_sub"},   en_sub,   model[0][1]);
        chk({req, " en_ind"},   en_ind,   model[0][2]);
        chk({req, " sense_a5"}, sense_a5, model[0][3]);
        chk({req, " en_b3"},    en_b3,    model[0][4]);
        chk({req, " lvl_a"},    lvl_a,    model[1][4:0]);
        chk({req, " lvl_b"},    lvl_b,    model[2][4:0]);
        chk({req, " lvl_c"},    lvl_c,    model[3][1:0]);
        chk({req, " chip_off"}, chip_off, (model[0][2:0] == 3'b000));
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H/2);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H/2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H/2);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(H/2);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0; tick(H/2);
        end
        m_sda = 1'b1; tick(H/2);
        m_scl = 1'b1; tick(H/2);
        ack = !sda_bus;
        tick(H/2);
        m_scl = 1'b0; tick(H/2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H/2);
            m_scl = 1'b1; tick(H/2);
            b[i] = sda_bus;
            tick(H/2);
            m_scl = 1'b0;
        end
        tick(H/2);
        m_sda = !give_ack; tick(H/2);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(H/2);
        m_sda = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] ra, input logic [7:0] d, output logic [2:0] acks);
        bit a;
        bus_start();
        send_byte({DEV, 1'b0}, a); acks[2] = a;
        send_byte(ra, a);          acks[1] = a;
        send_byte(d, a);           acks[0] = a;
        bus_stop();
        for (int i = 0; i < 4; i++) if (addr_of(i) == ra) model[i] = d;
    endtask

    task automatic read_reg(input logic [7:0] ra, output logic [7:0] d);
        bit a;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(ra, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] rd, rd2;
        bit a;
        model_por();
        tick(5);
        // R8: outputs held at reset values while the pin is low
        chk("R8 chip_off during reset", chip_off, 1);
        chk("R8 sda released during reset", sda_pull, 0);
        hw_rst_n = 1'b1;
        tick(5);

        // R5 power-on values, via fields and read-back
        check_fields("R5 por");
        for (int r = 0; r < 4; r++) begin
            read_reg(addr_of(r), rd);
            chk("R5 por readback", rd, model[r]);
        end

        // R4 R9: sweep data patterns through every mapped register
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] d;
                d = 8'((k * 73 + r * 29 + 11) & 255);
                write_reg(addr_of(r), d, acks);
                chk("R3 ack on three bytes", acks, 3'b111);
                check_fields("R9 fields after write");
                read_reg(addr_of(r), rd);
                chk("R4 readback", rd, d);
            end
        end

        // R6 unmapped addresses
        for (int u = 0; u < 8; u++) begin
            logic [7:0] ua;
            case (u)
                0: ua = 8'h00; 1: ua = 8'h11; 2: ua = 8'h20; 3: ua = 8'h9F;
                4: ua = 8'hA1; 5: ua = 8'hB8; 6: ua = 8'hCF; default: ua = 8'hFF;
            endcase
            write_reg(ua, 8'h5A, acks);
            chk("R6 unmapped write acked", acks, 3'b111);
            check_fields("R6 unmapped write discarded");
            read_reg(ua, rd);
            chk("R6 unmapped read zero", rd, 0);
        end

        // R2 every foreign device address is refused
        for (int ad = 0; ad < 128; ad++) begin
            if (ad == int'(DEV)) continue;
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            chk("R2 foreign address no ack", a, 0);
            if (ad == 7'h38) begin
                send_byte(8'hA0, a);
                chk("R2 ignored register byte", a, 0);
                send_byte(8'h00, a);
                chk("R2 ignored data byte", a, 0);
            end
            bus_stop();
        end
        check_fields("R2 nothing written by foreign transfer");

        // R4 several data bytes overwrite one register
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'hA0, a);
        send_byte(8'h11, a);
        send_byte(8'h0A, a);
        chk("R4 second data byte acked", a, 1);
        bus_stop();
        model[1] = 8'h0A;
        chk("R4 last data byte kept", lvl_a, 5'h0A);

        // R7 read with master ack repeats the register, then NACK silences
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'hB0, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        chk("R7 read address acked", a, 1);
        recv_byte(1'b1, rd);
        recv_byte(1'b0, rd2);
        chk("R7 first read byte", rd, model[2]);
        chk("R7 repeated read byte", rd2, model[2]);
        recv_byte(1'b0, rd);
        chk("R7 silent after nack", rd, 8'hFF);
        bus_stop();

        // R1 repeated START inside a write restarts the address phase
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'hB0, a);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk("R1 address after repeated start acked", a, 1);
        send_byte(8'hC0, a);
        send_byte(8'h02, a);
        bus_stop();
        model[3] = 8'h02;
        chk("R1 write after repeated start", lvl_c, 2'b10);
        chk("R1 bank b untouched", lvl_b, model[2][4:0]);

        // R1 a byte without START is not acknowledged
        send_byte({DEV, 1'b0}, a);
        chk("R1 no ack without start", a, 0);
        bus_stop();

        // R8 reset in mid-transfer
        write_reg(8'h10, 8'h07, acks);
        chk("R9 chip on with enables", chip_off, 0);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'hA0, a);
        m_sda = 1'b0; tick(H/2);
        m_scl = 1'b1; tick(H/2);
        hw_rst_n = 1'b0;
        #1;
        model_por();
        chk("R8 chip_off immediate", chip_off, 1);
        chk("R8 lvl_a immediate", lvl_a, 5'h00);
        tick(2);
        chk("R8 sda released", sda_pull, 0);
        check_fields("R8 reset values");
        tick(H/2);
        m_scl = 1'b0; tick(H/2);
        hw_rst_n = 1'b1;
        bus_stop();
        write_reg(8'hC0, 8'hF1, acks);
        chk("R8 write after reset acked", acks, 3'b111);
        check_fields("R8 fields after reset and write");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule